// File: doc/BRIEF.md
# Memory Map Probe Sequencer

A self-running test engine that maps where physical memory really lands behind a paging unit. It owns the paging unit's control byte and a byte-wide memory bus. After a start pulse it runs four passes. Each pass has a write phase and a read phase. The write phase walks every page selector value and every 16 KB window of the 64 KB address space, and stores a tag byte that identifies the page and window. The read phase walks the same grid again, possibly under the other paging mode, and streams every byte it reads to a result port.

Each result byte carries its pass, page and window index. A downstream agent can therefore see aliasing, holes (pages that return open-bus values) and pages that fail to move when the mode bit changes. The engine does not store or interpret the results. A done pulse ends the run.

Top module: `mem_probe_seq`

## Requirements
- R1: Passes 0..3 use the (write mode, read mode) pairs (0,0), (1,1), (1,0), (0,1) in that order. Each pass has a write phase followed by a read phase.
- R2: In each phase, pages 0..15 are visited in ascending order. Before the first access to a page, ctrl_wr_o pulses for one cycle with ctrl_byte_o = mode*0x80 + page.
- R3: Each visited page gets four single-cycle requests on consecutive cycles, with mem_addr_o = win*0x4000 for win 0,1,2,3 in that order. The control write for the next page follows in the next cycle.
- R4: A write request carries mem_we_o=1 and mem_wdata_o = page*4 + win. A read request carries mem_we_o=0.
- R5: The cycle after each read request, res_valid_o is high for one cycle. res_data_o then equals mem_rdata_i, and res_pass_o, res_page_o and res_win_o give that request's pass, page and window.
- R6: A run emits exactly 64 result bytes per pass, 256 in total. done_o pulses for one cycle in the cycle after the last result byte, and busy_o is low in the cycle after that.
- R7: A start_i pulse while busy_o is high has no effect on the run in progress and does not queue a further run.
- R8: Under reset and while idle, busy_o, done_o, res_valid_o, mem_req_o and ctrl_wr_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ctrl_wr_o | output | 1 | Paging control byte write strobe |
| ctrl_byte_o | output | 8 | Paging control byte: bit 7 mode, bits 3:0 page |
| mem_req_o | output | 1 | Memory request, one cycle per access |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write data (tag byte) |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read request |
| res_valid_o | output | 1 | Result byte valid |
| res_data_o | output | 8 | Result byte |
| res_pass_o | output | 2 | Pass index of the result |
| res_page_o | output | 4 | Page index of the result |
| res_win_o | output | 2 | Window index of the result |

## Verification
Two events share a cycle here. The result of the last window of a page comes out in the same cycle that the control byte for the next page is written. The same applies at a phase or pass boundary, where the next control write switches the paging mode. A bench memory model latches the control byte at that edge, and the model's read latency provokes this overlap on every page. A reference model of aliasing and holes, computed arithmetically over persistent memory, judges whether each streamed byte still reflects the old mapping and carries the old page's tag.

// File: rtl/mps_pkg.sv
package mps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ACC,
    ST_DRAIN,
    ST_FIN
  } seq_state_t;

  // pass order (0,0) (1,1) (1,0) (0,1)
  function automatic logic wr_mode(input logic [1:0] pass);
    return pass[0] ^ pass[1];
  endfunction

  function automatic logic rd_mode(input logic [1:0] pass);
    return pass[0];
  endfunction
endpackage

// File: rtl/mps_step_ctr.sv
module mps_step_ctr #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = &cnt_q;
endmodule

// File: rtl/mps_bus_drv.sv
module mps_bus_drv #(
  parameter int PAGE_W = 4,
  parameter int WIN_W  = 2,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              ctrl_st_i,
  input  logic              acc_st_i,
  input  logic [1:0]        pass_i,
  input  logic              rd_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [WIN_W-1:0]  win_i,
  output logic              ctrl_wr_o,
  output logic [DATA_W-1:0] ctrl_byte_o,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  import mps_pkg::*;

  localparam int TAG_W = PAGE_W + WIN_W;
  localparam int LOW_W = ADDR_W - WIN_W;

  logic mode;
  assign mode = rd_i ? rd_mode(pass_i) : wr_mode(pass_i);

  assign ctrl_wr_o   = ctrl_st_i;
  assign ctrl_byte_o = {mode, {(DATA_W-1-PAGE_W){1'b0}}, page_i};
  assign req_o       = acc_st_i;
  assign we_o        = acc_st_i & ~rd_i;
  assign addr_o      = {win_i, {LOW_W{1'b0}}};
  assign wdata_o     = {{(DATA_W-TAG_W){1'b0}}, page_i, win_i};
endmodule

// File: rtl/mps_res_stage.sv
module mps_res_stage #(
  parameter int PAGE_W = 4,
  parameter int WIN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [1:0]        pass_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [WIN_W-1:0]  win_i,
  output logic              valid_o,
  output logic [1:0]        pass_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [WIN_W-1:0]  win_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pass_o  <= '0;
      page_o  <= '0;
      win_o   <= '0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) begin
        pass_o <= pass_i;
        page_o <= page_i;
        win_o  <= win_i;
      end
    end
  end
endmodule

// File: rtl/mem_probe_seq.sv
module mem_probe_seq #(
  parameter int PAGE_W = 4,
  parameter int WIN_W  = 2,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ctrl_wr_o,
  output logic [DATA_W-1:0] ctrl_byte_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic [1:0]        res_pass_o,
  output logic [PAGE_W-1:0] res_page_o,
  output logic [WIN_W-1:0]  res_win_o
);
  import mps_pkg::*;

  // sequence index = {pass, phase, page, win}
  localparam int SEQ_W = 2 + 1 + PAGE_W + WIN_W;

  seq_state_t st_q, st_d;
  logic [SEQ_W-1:0]  seq;
  logic              seq_last, win_last, rd;
  logic [1:0]        pass;
  logic [PAGE_W-1:0] page;
  logic [WIN_W-1:0]  win;

  assign win      = seq[WIN_W-1:0];
  assign page     = seq[WIN_W +: PAGE_W];
  assign rd       = seq[WIN_W+PAGE_W];
  assign pass     = seq[SEQ_W-1 -: 2];
  assign win_last = &win;

  mps_step_ctr #(.W(SEQ_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_q == ST_IDLE && start_i),
    .inc_i (st_q == ST_ACC),
    .cnt_o (seq),
    .last_o(seq_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_CTRL;
      ST_CTRL:  st_d = ST_ACC;
      ST_ACC: begin
        if (seq_last)      st_d = ST_DRAIN;
        else if (win_last) st_d = ST_CTRL;
      end
      ST_DRAIN: st_d = ST_FIN;
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  mps_bus_drv #(
    .PAGE_W(PAGE_W), .WIN_W(WIN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_drv (
    .ctrl_st_i  (st_q == ST_CTRL),
    .acc_st_i   (st_q == ST_ACC),
    .pass_i     (pass),
    .rd_i       (rd),
    .page_i     (page),
    .win_i      (win),
    .ctrl_wr_o  (ctrl_wr_o),
    .ctrl_byte_o(ctrl_byte_o),
    .req_o      (mem_req_o),
    .we_o       (mem_we_o),
    .addr_o     (mem_addr_o),
    .wdata_o    (mem_wdata_o)
  );

  mps_res_stage #(.PAGE_W(PAGE_W), .WIN_W(WIN_W)) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (mem_req_o & ~mem_we_o),
    .pass_i (pass),
    .page_i (page),
    .win_i  (win),
    .valid_o(res_valid_o),
    .pass_o (res_pass_o),
    .page_o (res_page_o),
    .win_o  (res_win_o)
  );

  assign res_data_o = mem_rdata_i;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_FIN);

  // R6
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(res_valid_o) && !res_valid_o);

  // R5
  valid_follows_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(mem_req_o && !mem_we_o));

  // R3
  ctrl_req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_wr_o && mem_req_o));

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !ctrl_wr_o && !res_valid_o);

  // R7
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R4
  wr_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[WIN_W-1:0] == mem_addr_o[ADDR_W-1 -: WIN_W]);

  // R2
  ctrl_before_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_o |=> mem_req_o && mem_addr_o == '0);
endmodule

// File: tb/mem_probe_seq_tb.sv
module mem_probe_seq_tb_top;
  localparam int NPHYS = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, ctrl_wr, req, we, res_valid;
  logic [7:0] ctrl_byte, wdata, rdata, res_data;
  logic [15:0] addr;
  logic [1:0] res_pass, res_win;
  logic [3:0] res_page;

  always #2.5 clk = ~clk;

  mem_probe_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .ctrl_wr_o(ctrl_wr), .ctrl_byte_o(ctrl_byte), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .res_valid_o(res_valid), .res_data_o(res_data), .res_pass_o(res_pass),
    .res_page_o(res_page), .res_win_o(res_win)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // paging model: -1 = hole (0xFF), -2 = read-only page (0xA5)
  function automatic int phys(input bit mode, input int page, input int win);
    int p;
    if (win == 3) return 0;
    if (mode == 1'b0) begin
      if (win == 0) return -2;
      p = 1 + 2 * page + (win - 1);
    end else begin
      p = 1 + 3 * page + win;
    end
    return (p < NPHYS) ? p : -1;
  endfunction

  function automatic bit wmode(input int ps);
    return (ps == 1 || ps == 2);
  endfunction

  function automatic bit rmode(input int ps);
    return (ps == 1 || ps == 3);
  endfunction

  logic [7:0] mem [NPHYS];
  logic [7:0] ref_mem [NPHYS];
  logic [7:0] exp_res [256];
  logic [7:0] ctrl_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= 8'hEE;
      ctrl_q <= 8'h00;
      rdata  <= 8'h00;
    end else begin
      int p;
      if (ctrl_wr) ctrl_q <= ctrl_byte;
      if (req) begin
        p = phys(ctrl_q[7], int'(ctrl_q[3:0]), int'(addr[15:14]));
        if (we) begin
          if (p >= 0) mem[p] <= wdata;
        end else begin
          rdata <= (p == -1) ? 8'hFF : (p == -2) ? 8'hA5 : mem[p];
        end
      end
    end
  end

  task automatic build_expected();
    for (int ps = 0; ps < 4; ps++) begin
      for (int pg = 0; pg < 16; pg++)
        for (int w = 0; w < 4; w++) begin
          int p;
          p = phys(wmode(ps), pg, w);
          if (p >= 0) ref_mem[p] = 8'(pg * 4 + w);
        end
      for (int pg = 0; pg < 16; pg++)
        for (int w = 0; w < 4; w++) begin
          int p;
          p = phys(rmode(ps), pg, w);
          exp_res[ps*64 + pg*4 + w] = (p == -1) ? 8'hFF : (p == -2) ? 8'hA5 : ref_mem[p];
        end
    end
  endtask

  int ctrl_n, wr_n, rd_n, res_n, done_n, cyc, last_res_cyc;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (ctrl_wr) begin
        int ps, ph, pg;
        ps = ctrl_n / 32; ph = (ctrl_n / 16) % 2; pg = ctrl_n % 16;
        // R1 R2: mode per pass/phase, ascending pages
        chk(ctrl_byte == {(ph != 0) ? rmode(ps) : wmode(ps), 3'b000, 4'(pg)},
            "R1/R2", "ctrl byte", ctrl_byte, {(ph != 0) ? rmode(ps) : wmode(ps), 3'b000, 4'(pg)});
        ctrl_n++;
      end
      if (req && we) begin
        int pg, w;
        pg = (wr_n / 4) % 16; w = wr_n % 4;
        // R3
        chk(addr == 16'(w * 16'h4000), "R3", "write addr", addr, w * 16'h4000);
        // R4
        chk(wdata == 8'(pg * 4 + w), "R4", "write tag", wdata, pg * 4 + w);
        wr_n++;
      end
      if (req && !we) begin
        chk(addr == 16'((rd_n % 4) * 16'h4000), "R3", "read addr", addr, (rd_n % 4) * 16'h4000);
        rd_n++;
      end
      if (res_valid) begin
        // R5: data and tags
        chk(res_n < 256 && res_data == exp_res[res_n[7:0]], "R5", "result data", res_data,
            exp_res[res_n[7:0]]);
        chk({res_pass, res_page, res_win} == 8'(res_n), "R5", "result tag",
            {res_pass, res_page, res_win}, res_n);
        res_n++;
        last_res_cyc = cyc;
      end
      if (done) begin
        // R6
        chk(last_res_cyc == cyc - 1, "R6", "done after last byte", cyc - last_res_cyc, 1);
        chk(res_n == 256, "R6", "bytes per run", res_n, 256);
        done_n++;
      end
    end
  end

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic run(input bit poke_busy);
    build_expected();
    ctrl_n = 0; wr_n = 0; rd_n = 0; res_n = 0; done_n = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke_busy) begin
      repeat (300) @(negedge clk);
      start = 1'b1;  // R7: ignored while busy
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    // R6: idle after done
    chk(!busy, "R6", "busy after done", busy, 0);
    repeat (8) @(negedge clk);
    // R7: no extra run, counts intact
    chk(!busy && !res_valid && !req, "R7", "quiet after run", busy, 0);
    chk(res_n == 256, "R7", "total bytes", res_n, 256);
    chk(done_n == 1, "R7", "done pulses", done_n, 1);
    chk(ctrl_n == 128 && wr_n == 256 && rd_n == 256, "R2", "access counts", ctrl_n + wr_n + rd_n, 640);
  endtask

  initial begin
    for (int i = 0; i < NPHYS; i++) ref_mem[i] = 8'hEE;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk(!busy && !done && !res_valid && !req && !ctrl_wr, "R8", "reset outputs",
        {busy, done, res_valid, req, ctrl_wr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !req, "R8", "idle outputs", {busy, req}, 0);
    run(1'b0);
    run(1'b1);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected done");
    report();
  end
endmodule